// File: doc/BRIEF.md
# ECC Fault Injection and Error Reporting Unit

This unit sits next to a 64-bit memory datapath whose beats carry an 8-bit SECDED check byte. On the write side it can deliberately damage what gets stored. It XORs separate masks into the upper and lower 32-bit halves of the data and another mask into the check byte. A mirror option instead stores the low data byte in place of the check byte. All of this happens only while the injection enable is set. Software sets the enable before a test write and clears it before reading the location back.

On the read side the unit does not decode anything. The memory controller presents a per-beat classification (single-bit, multi-bit or memory-select error) together with the address, data, check byte and transaction attributes of the beat. The read half of a partial-width read-modify-write is reported through the same inputs. This is how a partial write to a location that already holds an uncorrectable error raises that error.

The unit keeps a saturating single-bit error counter with a threshold. It latches the first error seen into capture registers and flags later errors as multiple errors. Status flags are cleared by writing ones, and an interrupt is raised for enabled classes. Software reaches the unit through a single-cycle register port with byte enables.

Top module: `ecc_fault_unit`

## Requirements
- R1: After reset every register reads 0, `irq` is low, and the write path passes data and check byte through unchanged.
- R2: While the injection enable (bit 9 of register 0) is 0, `wr_data_out` equals `wr_data_in` and `wr_chk_out` equals `wr_chk_in`, whatever the masks and the mirror bit hold.
- R3: While injection is enabled and mirror (bit 8 of register 0) is 0, `wr_data_out` = `wr_data_in` XOR {register 1, register 2}, with register 1 as the upper word. `wr_chk_out` = `wr_chk_in` XOR register 0 bits 7:0.
- R4: While injection and mirror are both enabled, `wr_chk_out` equals `wr_data_out[7:0]`, and the data is still corrupted as in R3.
- R5: A register write updates only the byte lanes whose `reg_be` bit is set. Writing lane 0 of register 0 (the check mask) keeps the enable and mirror bits. In register 3 the counter (bits 7:0, lane 0) and the threshold (bits 23:16, lane 2) can each be written without changing the other.
- R6: Each enabled single-bit error adds one to the counter, which stops at 255 and never wraps.
- R7: When an enabled single-bit error brings the counter from below 255 to exactly a nonzero threshold, the counter returns to 0 and the single-bit flag (register 6 bit 0) sets. A threshold of 0 never sets the flag.
- R8: Each enabled multi-bit error sets register 6 bit 1, and each enabled memory-select error sets register 6 bit 2.
- R9: Register 4 bits 0, 1 and 2 disable the single-bit, multi-bit and memory-select classes. A disabled error changes no flag, does not count and is not captured.
- R10: Writing 1 to a bit of register 6 clears that flag and writing 0 leaves it. A flag that hardware sets in the same cycle stays set.
- R11: When the capture valid bit (register 11 bit 31) is 0, an enabled error loads registers 7–11 and sets valid. Register 7 holds the address, 8 the upper data word, 9 the lower data word and 10 the check byte. Register 11 holds beat in bits 2:0, size in 5:4, source in 12:8 and type in 17:16. When valid is 1, any enabled error leaves the capture as it is and sets the multiple-errors flag (register 6 bit 3).
- R12: Any write to a capture register (7 to 11) clears that register. Clearing register 11 drops valid and re-arms capture.
- R13: `irq` is high exactly when some flag among register 6 bits 2:0 is set together with the same bit of the interrupt enable register 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_be | input | 4 | Byte-lane enables for the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| wr_data_in | input | 64 | Write beat data from the controller |
| wr_chk_in | input | 8 | Check byte generated for the write beat |
| wr_data_out | output | 64 | Data to store, possibly corrupted |
| wr_chk_out | output | 8 | Check byte to store, possibly corrupted or mirrored |
| rd_valid | input | 1 | A read beat is being reported this cycle |
| rd_sbe | input | 1 | The beat had a correctable single-bit error |
| rd_mbe | input | 1 | The beat had an uncorrectable multi-bit error |
| rd_mse | input | 1 | The beat hit no valid memory select |
| rd_addr | input | ADDR_W | Address of the beat |
| rd_data | input | 64 | Raw data of the beat |
| rd_chk | input | 8 | Raw check byte of the beat |
| rd_beat | input | 3 | Beat number within the burst |
| rd_size | input | 2 | Transaction size code |
| rd_src | input | 5 | Transaction source code |
| rd_type | input | 2 | Transaction type code |
| irq | output | 1 | Error interrupt |

## Verification
Most internal faults surface at the register port within one cycle of the event that exposes them. A counter that wraps, misses the threshold or fails to reset shows up as a wrong value in register 3 on the next read. It also shows up as a single-bit flag and `irq` that rise early, late or never. A capture that reloads shows up as a changed address or attribute word after a second error. A lost multiple-error or set-over-clear decision shows up in register 6. Write-path mistakes are combinational and appear on `wr_data_out` and `wr_chk_out` in the same cycle as the mask and enable settings that cause them.

// File: rtl/ecc_fault_unit.sv
module ecc_fault_unit #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [3:0]        reg_addr,
  input  logic [3:0]        reg_be,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [63:0]       wr_data_in,
  input  logic [7:0]        wr_chk_in,
  output logic [63:0]       wr_data_out,
  output logic [7:0]        wr_chk_out,
  input  logic              rd_valid,
  input  logic              rd_sbe,
  input  logic              rd_mbe,
  input  logic              rd_mse,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [63:0]       rd_data,
  input  logic [7:0]        rd_chk,
  input  logic [2:0]        rd_beat,
  input  logic [1:0]        rd_size,
  input  logic [4:0]        rd_src,
  input  logic [1:0]        rd_type,
  output logic              irq
);

  localparam logic [3:0] A_INJ = 4'd0, A_MHI = 4'd1, A_MLO = 4'd2, A_SBE = 4'd3,
                         A_DIS = 4'd4, A_IEN = 4'd5, A_DET = 4'd6, A_CAD = 4'd7,
                         A_CHI = 4'd8, A_CLO = 4'd9, A_CCK = 4'd10, A_CAT = 4'd11;
  localparam logic [7:0] CNT_MAX = 8'hFF;

  logic [7:0]        inj_chk;
  logic              inj_mir, inj_en;
  logic [31:0]       mask_hi, mask_lo;
  logic [7:0]        sbe_cnt, sbe_thr;
  logic [2:0]        dis, ien;
  logic [3:0]        det;
  logic [ADDR_W-1:0] cap_addr;
  logic [31:0]       cap_hi, cap_lo;
  logic [7:0]        cap_chk;
  logic [2:0]        cap_beat;
  logic [1:0]        cap_size, cap_type;
  logic [4:0]        cap_src;
  logic              cap_vld;

  logic sbe_ev, mbe_ev, mse_ev, err_ev, sbe_hit, cnt_sw;
  logic [7:0] cnt_inc;
  logic [3:0] det_clr, det_set;

  function automatic logic sel(input logic [3:0] a);
    return reg_we && (reg_addr == a);
  endfunction

  assign wr_data_out = inj_en ? (wr_data_in ^ {mask_hi, mask_lo}) : wr_data_in;
  assign wr_chk_out  = !inj_en ? wr_chk_in :
                       inj_mir ? wr_data_out[7:0] : (wr_chk_in ^ inj_chk);

  assign sbe_ev  = rd_valid && rd_sbe && !dis[0];
  assign mbe_ev  = rd_valid && rd_mbe && !dis[1];
  assign mse_ev  = rd_valid && rd_mse && !dis[2];
  assign err_ev  = sbe_ev || mbe_ev || mse_ev;
  assign cnt_inc = (sbe_cnt == CNT_MAX) ? CNT_MAX : sbe_cnt + 8'd1;
  assign sbe_hit = sbe_ev && (sbe_thr != 8'd0) && (sbe_cnt != CNT_MAX) && (cnt_inc == sbe_thr);
  assign cnt_sw  = sel(A_SBE) && reg_be[0];
  assign det_clr = (sel(A_DET) && reg_be[0]) ? reg_wdata[3:0] : 4'd0;
  assign det_set = {err_ev && cap_vld, mse_ev, mbe_ev, sbe_hit};
  assign irq     = |(det[2:0] & ien);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inj_chk <= '0; inj_mir <= 1'b0; inj_en <= 1'b0;
      mask_hi <= '0; mask_lo <= '0;
      sbe_cnt <= '0; sbe_thr <= '0;
      dis <= '0; ien <= '0; det <= '0;
    end else begin
      if (sel(A_INJ) && reg_be[0]) inj_chk <= reg_wdata[7:0];
      if (sel(A_INJ) && reg_be[1]) {inj_en, inj_mir} <= reg_wdata[9:8];
      for (int i = 0; i < 4; i++) begin
        if (sel(A_MHI) && reg_be[i]) mask_hi[8*i +: 8] <= reg_wdata[8*i +: 8];
        if (sel(A_MLO) && reg_be[i]) mask_lo[8*i +: 8] <= reg_wdata[8*i +: 8];
      end
      if (cnt_sw)        sbe_cnt <= reg_wdata[7:0];
      else if (sbe_hit)  sbe_cnt <= 8'd0;
      else if (sbe_ev)   sbe_cnt <= cnt_inc;
      if (sel(A_SBE) && reg_be[2]) sbe_thr <= reg_wdata[23:16];
      if (sel(A_DIS) && reg_be[0]) dis <= reg_wdata[2:0];
      if (sel(A_IEN) && reg_be[0]) ien <= reg_wdata[2:0];
      det <= (det & ~det_clr) | det_set;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_addr <= '0; cap_hi <= '0; cap_lo <= '0; cap_chk <= '0;
      cap_beat <= '0; cap_size <= '0; cap_src <= '0; cap_type <= '0;
      cap_vld  <= 1'b0;
    end else if (err_ev && !cap_vld) begin
      cap_addr <= rd_addr;
      {cap_hi, cap_lo} <= rd_data;
      cap_chk  <= rd_chk;
      cap_beat <= rd_beat; cap_size <= rd_size;
      cap_src  <= rd_src;  cap_type <= rd_type;
      cap_vld  <= 1'b1;
    end else begin
      if (sel(A_CAD)) cap_addr <= '0;
      if (sel(A_CHI)) cap_hi   <= '0;
      if (sel(A_CLO)) cap_lo   <= '0;
      if (sel(A_CCK)) cap_chk  <= '0;
      if (sel(A_CAT)) begin
        cap_beat <= '0; cap_size <= '0; cap_src <= '0; cap_type <= '0;
        cap_vld  <= 1'b0;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_INJ: reg_rdata = {22'd0, inj_en, inj_mir, inj_chk};
      A_MHI: reg_rdata = mask_hi;
      A_MLO: reg_rdata = mask_lo;
      A_SBE: reg_rdata = {8'd0, sbe_thr, 8'd0, sbe_cnt};
      A_DIS: reg_rdata = {29'd0, dis};
      A_IEN: reg_rdata = {29'd0, ien};
      A_DET: reg_rdata = {28'd0, det};
      A_CAD: reg_rdata = 32'(cap_addr);
      A_CHI: reg_rdata = cap_hi;
      A_CLO: reg_rdata = cap_lo;
      A_CCK: reg_rdata = {24'd0, cap_chk};
      A_CAT: reg_rdata = {cap_vld, 13'd0, cap_type, 3'd0, cap_src, 2'd0, cap_size, 1'b0, cap_beat};
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/ecc_fault_unit_chk.sv
module ecc_fault_unit_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [3:0]        reg_addr,
  input logic [3:0]        reg_be,
  input logic [31:0]       reg_wdata,
  input logic              rd_valid,
  input logic              rd_sbe,
  input logic              rd_mbe,
  input logic              rd_mse,
  input logic [63:0]       wr_data_in,
  input logic [63:0]       wr_data_out,
  input logic              inj_en,
  input logic [7:0]        sbe_cnt,
  input logic [7:0]        sbe_thr,
  input logic [2:0]        dis,
  input logic [3:0]        det,
  input logic              cap_vld,
  input logic [ADDR_W-1:0] cap_addr
);
  logic c_cnt_wr, c_sbe, c_mbe, c_mse, c_any;
  assign c_cnt_wr = reg_we && reg_addr == 4'd3 && reg_be[0];
  assign c_sbe = rd_valid && rd_sbe && !dis[0];
  assign c_mbe = rd_valid && rd_mbe && !dis[1];
  assign c_mse = rd_valid && rd_mse && !dis[2];
  assign c_any = c_sbe || c_mbe || c_mse;

  AST_PASS_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !inj_en |-> wr_data_out == wr_data_in); // R2
  AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (sbe_cnt == 8'hFF && !c_cnt_wr) |=> sbe_cnt == 8'hFF); // R6
  AST_THR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (c_sbe && !c_cnt_wr && sbe_thr != 8'd0 && sbe_cnt != 8'hFF && 8'(sbe_cnt + 8'd1) == sbe_thr)
    |=> (sbe_cnt == 8'd0 && det[0])); // R7
  AST_DISABLED_MBE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_mbe && dis[1] && !det[1]) |=> !det[1]); // R9
  AST_W1C_MSE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 4'd6 && reg_be[0] && reg_wdata[2] && !c_mse) |=> !det[2]); // R10
  AST_MME_ON_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_vld && c_any) |=> det[3]); // R11
  AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_vld && !reg_we) |=> (cap_vld && $stable(cap_addr))); // R11
endmodule

bind ecc_fault_unit ecc_fault_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_be(reg_be),
  .reg_wdata(reg_wdata), .rd_valid(rd_valid), .rd_sbe(rd_sbe), .rd_mbe(rd_mbe),
  .rd_mse(rd_mse), .wr_data_in(wr_data_in), .wr_data_out(wr_data_out),
  .inj_en(inj_en), .sbe_cnt(sbe_cnt), .sbe_thr(sbe_thr), .dis(dis), .det(det),
  .cap_vld(cap_vld), .cap_addr(cap_addr)
);

// File: tb/test_ecc_fault_unit.sv
module test_ecc_fault_unit;
  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [3:0] reg_addr = 0, reg_be = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [63:0] wr_data_in = 0, wr_data_out;
  logic [7:0] wr_chk_in = 0, wr_chk_out;
  logic rd_valid = 0, rd_sbe = 0, rd_mbe = 0, rd_mse = 0;
  logic [31:0] rd_addr = 0;
  logic [63:0] rd_data = 0;
  logic [7:0] rd_chk = 0;
  logic [2:0] rd_beat = 0;
  logic [1:0] rd_size = 0, rd_type = 0;
  logic [4:0] rd_src = 0;
  logic irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ecc_fault_unit i_ecc_fault_unit (.*);

  // {ctrl, mask_hi, mask_lo, data_in, chk_in}
  localparam logic [167:0] VEC [4] = '{
    {32'h0000_0000, 32'hFFFF_0000, 32'h0000_0001, 64'hFEDC_BA98_7654_3210, 8'h5A},
    {32'h0000_023C, 32'h8000_0000, 32'h0000_0001, 64'h0123_4567_89AB_CDEF, 8'hA5},
    {32'h0000_03FF, 32'h0000_0000, 32'h0000_00F0, 64'h1122_3344_5566_7788, 8'h11},
    {32'h0000_010F, 32'h0F0F_0F0F, 32'hF0F0_F0F0, 64'hDEAD_BEEF_CAFE_F00D, 8'h3C}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d; reg_be = be;
    @(negedge clk);
    reg_we = 0; reg_be = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic ev(input logic s, input logic m, input logic e, input logic [31:0] a,
                    input logic [63:0] d, input logic [7:0] c, input logic [2:0] bt,
                    input logic [1:0] sz, input logic [4:0] sr, input logic [1:0] ty);
    @(negedge clk);
    rd_valid = 1; rd_sbe = s; rd_mbe = m; rd_mse = e;
    rd_addr = a; rd_data = d; rd_chk = c; rd_beat = bt; rd_size = sz; rd_src = sr; rd_type = ty;
    @(negedge clk);
    rd_valid = 0; rd_sbe = 0; rd_mbe = 0; rd_mse = 0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    for (int a = 0; a < 12; a++) begin
      rd(4'(a), v);
      check($sformatf("R1 reg %0d after reset", a), 64'(v), 64'd0);
    end
    wr_data_in = 64'h0F1E_2D3C_4B5A_6978; wr_chk_in = 8'h96;
    #1;
    check("R1 irq low", 64'(irq), 64'd0);
    check("R1 data passthrough", wr_data_out, wr_data_in);
    check("R1 check passthrough", 64'(wr_chk_out), 64'(wr_chk_in));

    // R2 R3 R4 write-path table
    for (int k = 0; k < 4; k++) begin
      logic [31:0] ctl, mh, ml;
      logic [63:0] din, edat;
      logic [7:0] cin, echk;
      {ctl, mh, ml, din, cin} = VEC[k];
      wr(4'd0, ctl, 4'b0011);
      wr(4'd1, mh, 4'b1111);
      wr(4'd2, ml, 4'b1111);
      @(negedge clk);
      wr_data_in = din; wr_chk_in = cin;
      #1;
      edat = ctl[9] ? (din ^ {mh, ml}) : din;
      echk = !ctl[9] ? cin : (ctl[8] ? edat[7:0] : (cin ^ ctl[7:0]));
      check($sformatf("R2/R3 vector %0d data", k), wr_data_out, edat);
      check($sformatf("R3/R4 vector %0d check byte", k), 64'(wr_chk_out), 64'(echk));
    end

    // R5 byte lanes
    wr(4'd0, 32'h0000_03AA, 4'b0011);
    wr(4'd0, 32'h0000_0055, 4'b0001);
    rd(4'd0, v); check("R5 mask write keeps enable and mirror", 64'(v), 64'h355);
    wr(4'd0, 32'h0, 4'b0011);
    wr(4'd3, 32'h0005_0000, 4'b0100);
    wr(4'd3, 32'h0000_0003, 4'b0001);
    rd(4'd3, v); check("R5 counter and threshold independent", 64'(v), 64'h0005_0003);
    wr(4'd3, 32'hFFFF_FF07, 4'b0001);
    rd(4'd3, v); check("R5 lane 0 only updates counter", 64'(v), 64'h0005_0007);

    // R6 R7 R11 R13 threshold and capture
    wr(4'd3, 32'h0003_0000, 4'b0101);
    wr(4'd5, 32'h1, 4'b0001);
    ev(1, 0, 0, 32'h1000, 64'h1111_2222_3333_4444, 8'h3C, 3'd5, 2'd2, 5'h13, 2'd1);
    rd(4'd3, v); check("R6 counter after one", 64'(v), 64'h0003_0001);
    rd(4'd6, v); check("R7 no flag below threshold", 64'(v), 64'h0);
    ev(1, 0, 0, 32'h2000, 64'h5555_6666_7777_8888, 8'h11, 3'd1, 2'd1, 5'h01, 2'd2);
    ev(1, 0, 0, 32'h2000, 64'h5555_6666_7777_8888, 8'h11, 3'd1, 2'd1, 5'h01, 2'd2);
    rd(4'd3, v); check("R7 counter restarts at threshold", 64'(v), 64'h0003_0000);
    rd(4'd6, v); check("R7/R11 single-bit and multiple flags", 64'(v), 64'h9);
    #1 check("R13 irq with single-bit enabled", 64'(irq), 64'd1);
    rd(4'd7, v);  check("R11 captured address", 64'(v), 64'h1000);
    rd(4'd8, v);  check("R11 captured upper word", 64'(v), 64'h1111_2222);
    rd(4'd9, v);  check("R11 captured lower word", 64'(v), 64'h3333_4444);
    rd(4'd10, v); check("R11 captured check byte", 64'(v), 64'h3C);
    rd(4'd11, v); check("R11 captured attributes", 64'(v), 64'h8001_1325);

    // R10 write-one-to-clear
    wr(4'd6, 32'h1, 4'b0001);
    rd(4'd6, v); check("R10 clear single-bit flag", 64'(v), 64'h8);
    #1 check("R13 irq drops with flag", 64'(irq), 64'd0);
    wr(4'd6, 32'h0, 4'b0001);
    rd(4'd6, v); check("R10 writing zero keeps flags", 64'(v), 64'h8);
    wr(4'd6, 32'h8, 4'b0001);
    rd(4'd6, v); check("R10 clear multiple flag", 64'(v), 64'h0);
    @(negedge clk);
    reg_we = 1; reg_addr = 4'd6; reg_wdata = 32'h2; reg_be = 4'b0001;
    rd_valid = 1; rd_mbe = 1; rd_addr = 32'h4000;
    @(negedge clk);
    reg_we = 0; reg_be = 0; rd_valid = 0; rd_mbe = 0;
    rd(4'd6, v); check("R10 set wins over clear", 64'(v), 64'hA);
    wr(4'd6, 32'hF, 4'b0001);

    // R12 capture clear and re-arm
    wr(4'd11, 32'h0, 4'b1111);
    rd(4'd11, v); check("R12 attribute word cleared", 64'(v), 64'h0);
    rd(4'd7, v);  check("R12 address kept until written", 64'(v), 64'h1000);
    wr(4'd7, 32'h0, 4'b1111);
    wr(4'd8, 32'h0, 4'b1111);
    wr(4'd9, 32'h0, 4'b1111);
    wr(4'd10, 32'h0, 4'b1111);
    rd(4'd9, v); check("R12 lower word cleared", 64'(v), 64'h0);
    ev(0, 0, 1, 32'h3000, 64'hAAAA_0000_0000_BBBB, 8'h77, 3'd2, 2'd3, 5'h1F, 2'd3);
    rd(4'd7, v); check("R12 re-armed capture address", 64'(v), 64'h3000);
    rd(4'd6, v); check("R8 memory-select flag without multiple", 64'(v), 64'h4);

    // R13 interrupt enable
    wr(4'd5, 32'h4, 4'b0001);
    #1 check("R13 irq memory-select enabled", 64'(irq), 64'd1);
    wr(4'd5, 32'h0, 4'b0001);
    #1 check("R13 irq masked", 64'(irq), 64'd0);
    wr(4'd6, 32'hF, 4'b0001);

    // R9 disabled classes
    wr(4'd11, 32'h0, 4'b1111);
    wr(4'd4, 32'h7, 4'b0001);
    ev(1, 0, 0, 32'h5000, 64'h1, 8'h1, 3'd0, 2'd0, 5'h0, 2'd0);
    ev(0, 1, 0, 32'h5000, 64'h1, 8'h1, 3'd0, 2'd0, 5'h0, 2'd0);
    ev(0, 0, 1, 32'h5000, 64'h1, 8'h1, 3'd0, 2'd0, 5'h0, 2'd0);
    rd(4'd6, v);  check("R9 disabled errors set no flag", 64'(v), 64'h0);
    rd(4'd3, v);  check("R9 disabled single-bit not counted", 64'(v), 64'h0003_0000);
    rd(4'd11, v); check("R9 disabled errors not captured", 64'(v), 64'h0);
    wr(4'd4, 32'h0, 4'b0001);

    // R6 saturation
    wr(4'd3, 32'h000A_00FA, 4'b0101);
    for (int n = 0; n < 7; n++)
      ev(1, 0, 0, 32'h6000, 64'h2, 8'h2, 3'd0, 2'd0, 5'h0, 2'd0);
    rd(4'd3, v); check("R6 counter saturates at 255", 64'(v), 64'h000A_00FF);
    rd(4'd6, v); check("R6 no single-bit flag when saturated", 64'(v & 32'h1), 64'h0);

    // R8 R13 multi-bit
    wr(4'd6, 32'hF, 4'b0001);
    wr(4'd5, 32'h2, 4'b0001);
    ev(0, 1, 0, 32'h7000, 64'h3, 8'h3, 3'd0, 2'd0, 5'h0, 2'd0);
    rd(4'd6, v); check("R8 multi-bit flag", 64'(v & 32'h2), 64'h2);
    #1 check("R13 irq multi-bit enabled", 64'(irq), 64'd1);

    done = 1;
    finish_run();
  end
endmodule